// File: doc/BRIEF.md
# Dual-clock serial field delay memory

This block is a byte-wide serial memory with one write port and one read port. Each port has its own clock. The two clocks are unrelated, may run at different rates, and either one may be stopped, high or low, for any length of time without losing stored words. Each port walks through the array with its own address counter. A port reset returns that counter to location zero. The delay between the input stream and the output stream therefore depends only on how far apart the write reset and the read reset are issued. The block works as a programmable digital delay line, for example one video field long.

Both ports have two enables. The primary enable (`wr_we`, `rd_re`) decides whether the address advances at all. The secondary enable (`wr_ie`, `rd_oe`) only masks the data. With the secondary enable low, a write leaves the location unchanged and a read presents nothing, but the address still steps. This allows selective overwrite of regions, such as an inset picture, and it allows words to be dropped from the output stream. The first `LINE` locations are mirrored in a small line buffer, so the first word after a read reset comes out on the first read edge.

Each port is controlled by a four-state machine. The write port states are `WR_CLEAR` (reset taken), `WR_PUT` (word stored, address stepped), `WR_MASK` (nothing stored, address stepped) and `WR_STALL` (nothing stored, address held). On every write clock edge the machine moves to the state selected by the inputs, in priority order: reset, then write-enable low, then input-enable low, otherwise put. The read port states are `RD_CLEAR`, `RD_SHOW` (word fetched and presented), `RD_DROP` (address stepped, nothing presented) and `RD_IDLE` (address held). They are chosen the same way from reset, `rd_re` and `rd_oe`. Any state can move to any other state.

Top module: `field_delay_mem`

## Requirements
- R1: A write clock edge with `wr_rst` high sets the write address to 0, stores nothing and overrides both write enables. The next stored word goes to location 0.
- R2: A read clock edge with `rd_rst` high sets the read address to 0 and presents nothing. The first later edge with `rd_re` and `rd_oe` high presents the word at location 0 right after that edge, with no extra cycle.
- R3: A write clock edge with `wr_rst` low and `wr_we` low neither stores a word nor moves the write address.
- R4: A write clock edge with `wr_we` high and `wr_ie` low leaves the addressed location unchanged and advances the write address by one.
- R5: A read clock edge with `rd_rst` low and `rd_re` low holds the read address. After that edge `rd_valid` is 0.
- R6: A read clock edge with `rd_re` high and `rd_oe` low advances the read address, so that word is skipped. After that edge `rd_valid` is 0 and `rd_dout` is 0. `rd_dout` is 0 whenever `rd_valid` is 0.
- R7: After a read clock edge with `rd_rst` low and both `rd_re` and `rd_oe` high, `rd_valid` is 1 and `rd_dout` holds the word at the read address sampled on that edge, until the next read clock edge.
- R8: Both address counters step from `DEPTH-1` back to 0.
- R9: With both ports running continuously, the read stream equals the write stream. Read word i is the i-th word written after the write reset, whatever the offset between the two resets.
- R10: Stored words are kept while either clock is halted for a long time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| wr_rst | input | 1 | Write address reset, sampled on the write clock |
| wr_we | input | 1 | Write enable: advance the address and allow a store |
| wr_ie | input | 1 | Input enable: store the word when high, keep the old contents when low |
| wr_din | input | WIDTH | Write data |
| rd_clk | input | 1 | Read port clock |
| rd_rst | input | 1 | Read address reset, sampled on the read clock |
| rd_re | input | 1 | Read enable: advance the address |
| rd_oe | input | 1 | Output enable: present the fetched word when high |
| rd_dout | output | WIDTH | Read data, 0 when not valid |
| rd_valid | output | 1 | High for the cycle after a presented read |

## Verification
The bench stalls and masks on random edges, both during writes and reads. A design that confused the two enables would shift every later word by one location, or would overwrite the words that were meant to be kept. Reading more than one full pass of the array tests the wrap at `DEPTH-1` and the switch from the line buffer to the main array. An off-by-one in either place returns stale words. A directed read just after a read reset checks that location 0 comes out on the first read edge. A prefetch that was too slow would return a valid flag or data one cycle late. A long halt of each clock, followed by a concurrent run with the read reset issued some writes after the write reset, checks that stored words survive the halt and that the delay is set only by the reset offset.

// File: rtl/fdm_pkg.sv
package fdm_pkg;

    // Action taken by the write port on its last clock edge.
    typedef enum logic [1:0] {
        WR_CLEAR = 2'd0,
        WR_PUT   = 2'd1,
        WR_MASK  = 2'd2,
        WR_STALL = 2'd3
    } wr_state_e;

    // Action taken by the read port on its last clock edge.
    typedef enum logic [1:0] {
        RD_CLEAR = 2'd0,
        RD_SHOW  = 2'd1,
        RD_DROP  = 2'd2,
        RD_IDLE  = 2'd3
    } rd_state_e;

endpackage

// File: rtl/fdm_wr_ctrl.sv
module fdm_wr_ctrl
    import fdm_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          ie,
    output logic [AW-1:0] addr,
    output logic          store,
    output wr_state_e     state
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    wr_state_e     nxt;
    logic [AW-1:0] addr_nxt;

    // Transition selection: reset beats every enable.
    always_comb begin
        if (rst) begin
            nxt = WR_CLEAR;
        end else if (!we) begin
            nxt = WR_STALL;
        end else if (!ie) begin
            nxt = WR_MASK;
        end else begin
            nxt = WR_PUT;
        end
    end

    // Outputs of the transition: address step and store strobe.
    always_comb begin
        addr_nxt = addr;
        store    = 1'b0;
        unique case (nxt)
            WR_CLEAR: addr_nxt = '0;
            WR_PUT: begin
                store    = 1'b1;
                addr_nxt = (addr == LAST) ? '0 : addr + AW'(1);
            end
            WR_MASK:  addr_nxt = (addr == LAST) ? '0 : addr + AW'(1);
            WR_STALL: addr_nxt = addr;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        state <= nxt;
        addr  <= addr_nxt;
    end

endmodule

// File: rtl/fdm_rd_ctrl.sv
module fdm_rd_ctrl
    import fdm_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = 11,
    parameter int W     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          re,
    input  logic          oe,
    input  logic [W-1:0]  word,
    output logic [AW-1:0] addr,
    output logic          fetch,
    output rd_state_e     state,
    output logic [W-1:0]  dout,
    output logic          valid
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rd_state_e     nxt;
    logic [AW-1:0] addr_nxt;

    // Transition selection: reset first, then the two enables.
    always_comb begin
        if (rst) begin
            nxt = RD_CLEAR;
        end else if (!re) begin
            nxt = RD_IDLE;
        end else if (!oe) begin
            nxt = RD_DROP;
        end else begin
            nxt = RD_SHOW;
        end
    end

    // Transition side effects: fetch strobe and address step.
    always_comb begin
        addr_nxt = addr;
        fetch    = 1'b0;
        unique case (nxt)
            RD_CLEAR: addr_nxt = '0;
            RD_SHOW: begin
                fetch    = 1'b1;
                addr_nxt = (addr == LAST) ? '0 : addr + AW'(1);
            end
            RD_DROP:  addr_nxt = (addr == LAST) ? '0 : addr + AW'(1);
            RD_IDLE:  addr_nxt = addr;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        state <= nxt;
        addr  <= addr_nxt;
    end

    // Output process: only the show state drives data.
    always_comb begin
        valid = 1'b0;
        dout  = '0;
        unique case (state)
            RD_SHOW: begin
                valid = 1'b1;
                dout  = word;
            end
            RD_CLEAR, RD_DROP, RD_IDLE: begin
                valid = 1'b0;
                dout  = '0;
            end
        endcase
    end

endmodule

// File: rtl/fdm_linebuf.sv
module fdm_linebuf #(
    parameter int W    = 8,
    parameter int LINE = 256,
    parameter int AW   = 11
) (
    input  logic          wr_clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_word,
    output logic          rd_hit
);

    localparam int LW = $clog2(LINE);

    logic [W-1:0] head [LINE];
    logic         wr_hit;

    // Compare with one extra bit so LINE may equal a power of two.
    assign wr_hit = ({1'b0, wr_addr} < (AW + 1)'(LINE));
    assign rd_hit = ({1'b0, rd_addr} < (AW + 1)'(LINE));

    // Mirror of the start of the array, written with the main array.
    always_ff @(posedge wr_clk) begin
        if (wr_en && wr_hit) begin
            head[wr_addr[LW-1:0]] <= wr_data;
        end
    end

    assign rd_word = head[rd_addr[LW-1:0]];

endmodule

// File: rtl/fdm_store.sv
module fdm_store #(
    parameter int W     = 8,
    parameter int DEPTH = 2048,
    parameter int LINE  = 256,
    parameter int AW    = 11
) (
    input  logic          wr_clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_clk,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_word
);

    logic [W-1:0] cells [DEPTH];
    logic [W-1:0] pick;

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    generate
        if (LINE >= 2) begin : g_line
            logic [W-1:0] lb_word;
            logic         lb_hit;

            fdm_linebuf #(
                .W    (W),
                .LINE (LINE),
                .AW   (AW)
            ) i_linebuf (
                .wr_clk  (wr_clk),
                .wr_en   (wr_en),
                .wr_addr (wr_addr),
                .wr_data (wr_data),
                .rd_addr (rd_addr),
                .rd_word (lb_word),
                .rd_hit  (lb_hit)
            );

            assign pick = lb_hit ? lb_word : cells[rd_addr];
        end else begin : g_direct
            assign pick = cells[rd_addr];
        end
    endgenerate

    // Registered read: a collision on one shared edge returns old data.
    always_ff @(posedge rd_clk) begin
        if (rd_en) begin
            rd_word <= pick;
        end
    end

endmodule

// File: rtl/field_delay_mem.sv
module field_delay_mem
    import fdm_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2048,
    parameter int LINE  = 256
) (
    input  logic             wr_clk,
    input  logic             wr_rst,
    input  logic             wr_we,
    input  logic             wr_ie,
    input  logic [WIDTH-1:0] wr_din,
    input  logic             rd_clk,
    input  logic             rd_rst,
    input  logic             rd_re,
    input  logic             rd_oe,
    output logic [WIDTH-1:0] rd_dout,
    output logic             rd_valid
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0]    wr_addr;
    logic [AW-1:0]    rd_addr;
    logic             wr_store;
    logic             rd_fetch;
    logic [WIDTH-1:0] rd_word;
    wr_state_e        wr_state;
    rd_state_e        rd_state;

    fdm_wr_ctrl #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) i_wr_ctrl (
        .clk   (wr_clk),
        .rst   (wr_rst),
        .we    (wr_we),
        .ie    (wr_ie),
        .addr  (wr_addr),
        .store (wr_store),
        .state (wr_state)
    );

    fdm_store #(
        .W     (WIDTH),
        .DEPTH (DEPTH),
        .LINE  (LINE),
        .AW    (AW)
    ) i_store (
        .wr_clk  (wr_clk),
        .wr_en   (wr_store),
        .wr_addr (wr_addr),
        .wr_data (wr_din),
        .rd_clk  (rd_clk),
        .rd_en   (rd_fetch),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    fdm_rd_ctrl #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .W     (WIDTH)
    ) i_rd_ctrl (
        .clk   (rd_clk),
        .rst   (rd_rst),
        .re    (rd_re),
        .oe    (rd_oe),
        .word  (rd_word),
        .addr  (rd_addr),
        .fetch (rd_fetch),
        .state (rd_state),
        .dout  (rd_dout),
        .valid (rd_valid)
    );

endmodule

// File: rtl/fdm_checker.sv
module fdm_checker #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11,
    parameter int W     = 8
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          wr_we,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          rd_re,
    input logic          rd_oe,
    input logic          rd_valid,
    input logic [W-1:0]  rd_dout,
    input logic [AW-1:0] wr_addr,
    input logic [AW-1:0] rd_addr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Each port is checked only after its first reset edge.
    logic wr_live = 1'b0;
    logic rd_live = 1'b0;

    always_ff @(posedge wr_clk) if (wr_rst) wr_live <= 1'b1;
    always_ff @(posedge rd_clk) if (rd_rst) rd_live <= 1'b1;

    AST_WR_RST_ZERO: assert property (@(posedge wr_clk) disable iff (!wr_live)
        wr_rst |=> (wr_addr == '0)); // R1
    AST_WR_STALL_HOLD: assert property (@(posedge wr_clk) disable iff (!wr_live)
        (!wr_rst && !wr_we) |=> (wr_addr == $past(wr_addr))); // R3
    AST_WR_STEP: assert property (@(posedge wr_clk) disable iff (!wr_live)
        (!wr_rst && wr_we && wr_addr != LAST) |=> (wr_addr == $past(wr_addr) + AW'(1))); // R4
    AST_WR_WRAP: assert property (@(posedge wr_clk) disable iff (!wr_live)
        (!wr_rst && wr_we && wr_addr == LAST) |=> (wr_addr == '0)); // R8
    AST_RD_RST_ZERO: assert property (@(posedge rd_clk) disable iff (!rd_live)
        rd_rst |=> (rd_addr == '0 && !rd_valid)); // R2
    AST_RD_IDLE_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_live)
        (!rd_rst && !rd_re) |=> (rd_addr == $past(rd_addr) && !rd_valid)); // R5
    AST_RD_DROP_STEP: assert property (@(posedge rd_clk) disable iff (!rd_live)
        (!rd_rst && rd_re && !rd_oe && rd_addr != LAST) |=> (rd_addr == $past(rd_addr) + AW'(1) && !rd_valid)); // R6
    AST_RD_QUIET: assert property (@(posedge rd_clk) disable iff (!rd_live)
        !rd_valid |-> (rd_dout == '0)); // R6
    AST_RD_VALID_TIMING: assert property (@(posedge rd_clk) disable iff (!rd_live)
        (!rd_rst && rd_re && rd_oe) |=> rd_valid); // R7
    AST_RD_WRAP: assert property (@(posedge rd_clk) disable iff (!rd_live)
        (!rd_rst && rd_re && rd_addr == LAST) |=> (rd_addr == '0)); // R8

endmodule

bind field_delay_mem fdm_checker #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .W     (WIDTH)
) i_fdm_checker (
    .wr_clk   (wr_clk),
    .wr_rst   (wr_rst),
    .wr_we    (wr_we),
    .rd_clk   (rd_clk),
    .rd_rst   (rd_rst),
    .rd_re    (rd_re),
    .rd_oe    (rd_oe),
    .rd_valid (rd_valid),
    .rd_dout  (rd_dout),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr)
);

// File: tb/test_field_delay_mem.sv
module test_field_delay_mem;

    localparam int DEPTH = 64;
    localparam int LINE  = 8;
    localparam int W     = 8;

    logic wr_clk = 1'b0;
    logic rd_clk = 1'b0;
    logic wr_run = 1'b1;
    logic rd_run = 1'b1;

    // 50 MHz write clock; slower, unrelated read clock; both can be halted low.
    always #10 wr_clk = wr_run ? ~wr_clk : 1'b0;
    always #17 rd_clk = rd_run ? ~rd_clk : 1'b0;

    logic         wr_rst = 1'b0, wr_we = 1'b0, wr_ie = 1'b0;
    logic [W-1:0] wr_din = '0;
    logic         rd_rst = 1'b0, rd_re = 1'b0, rd_oe = 1'b0;
    logic [W-1:0] rd_dout;
    logic         rd_valid;

    field_delay_mem #(
        .WIDTH (W),
        .DEPTH (DEPTH),
        .LINE  (LINE)
    ) i_field_delay_mem (
        .wr_clk   (wr_clk),
        .wr_rst   (wr_rst),
        .wr_we    (wr_we),
        .wr_ie    (wr_ie),
        .wr_din   (wr_din),
        .rd_clk   (rd_clk),
        .rd_rst   (rd_rst),
        .rd_re    (rd_re),
        .rd_oe    (rd_oe),
        .rd_dout  (rd_dout),
        .rd_valid (rd_valid)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [W-1:0] ref_mem [DEPTH];
    int           ref_wa = 0;
    int           ref_ra = 0;
    logic [W-1:0] stream [$];

    function automatic int step_addr(int a);
        return (a == DEPTH - 1) ? 0 : a + 1;
    endfunction

    task automatic check(bit ok, string tag, logic [W:0] act, logic [W:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual valid/data %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr_cycle(bit rst, bit we, bit ie, logic [W-1:0] d);
        @(negedge wr_clk);
        wr_rst = rst; wr_we = we; wr_ie = ie; wr_din = d;
        @(posedge wr_clk);
        if (rst) begin
            ref_wa = 0;
        end else if (we) begin
            if (ie) ref_mem[ref_wa] = d;
            ref_wa = step_addr(ref_wa);
        end
    endtask

    task automatic rd_cycle(bit rst, bit re, bit oe, string tag);
        logic         ev;
        logic [W-1:0] ed;
        @(negedge rd_clk);
        rd_rst = rst; rd_re = re; rd_oe = oe;
        @(posedge rd_clk);
        ev = !rst && re && oe;
        ed = ev ? ref_mem[ref_ra] : '0;
        if (rst) ref_ra = 0;
        else if (re) ref_ra = step_addr(ref_ra);
        #5;
        check(rd_valid === ev && rd_dout === ed, tag, {rd_valid, rd_dout}, {ev, ed});
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // Reset both ports; read side shows nothing.
        wr_cycle(1, 0, 0, '0);
        rd_cycle(1, 1, 1, "R2 reset state");

        // Fill the array with read clock halted, then a random pass that wraps.
        rd_run = 1'b0;
        for (int i = 0; i < DEPTH; i++) wr_cycle(0, 1, 1, W'(i ^ 8'h5A));
        for (int i = 0; i < DEPTH + 6; i++) begin
            wr_cycle(0, ($urandom % 5) != 0, ($urandom % 4) != 0, W'($urandom));
        end
        wr_cycle(0, 0, 1, '0);

        // Long halt of the write clock, then read back.
        wr_run = 1'b0;
        #3000;
        rd_run = 1'b1;
        rd_cycle(1, 0, 0, "R2");
        rd_cycle(0, 1, 1, "R2 first word no latency");
        for (int i = 0; i < 2 * DEPTH + 4; i++) begin
            bit r  = ($urandom % 50) == 0;
            bit re = ($urandom % 7) != 0;
            bit oe = ($urandom % 5) != 0;
            if (r)        rd_cycle(1, re, oe, "R2");
            else if (!re) rd_cycle(0, 0, oe, "R5");
            else if (!oe) rd_cycle(0, 1, 0, "R6");
            else          rd_cycle(0, 1, 1, "R7 R8 R10");
        end

        // Directed stall and mask on the write side.
        wr_run = 1'b1;
        wr_cycle(1, 1, 1, 8'hEE);
        wr_cycle(0, 1, 1, 8'hA1);
        wr_cycle(0, 0, 1, 8'hB2);
        wr_cycle(0, 1, 0, 8'hC3);
        wr_cycle(0, 1, 1, 8'hD4);
        wr_cycle(0, 0, 0, '0);
        check(ref_mem[0] == 8'hA1, "R1", {1'b1, ref_mem[0]}, {1'b1, 8'hA1});
        rd_cycle(1, 0, 0, "R2");
        rd_cycle(0, 1, 1, "R1 location zero");
        rd_cycle(0, 1, 1, "R3 R4 kept word");
        rd_cycle(0, 1, 1, "R3 R4 stepped word");

        // Concurrent delay line: read reset a dozen writes after write reset.
        stream.delete();
        fork
            begin
                wr_cycle(1, 1, 1, '0);
                for (int i = 0; i < 50; i++) begin
                    logic [W-1:0] d = W'($urandom);
                    wr_cycle(0, 1, 1, d);
                    stream.push_back(d);
                end
                wr_cycle(0, 0, 0, '0);
            end
            begin
                wait (stream.size() >= 12);
                rd_cycle(1, 0, 0, "R2");
                for (int i = 0; i < 30; i++) begin
                    rd_cycle(0, 1, 1, "R7");
                    check(rd_dout === stream[i], "R9 R1 delayed stream",
                          {1'b1, rd_dout}, {1'b1, stream[i]});
                end
            end
        join

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule